// File: doc/BRIEF.md
# CSR Read-Modify-Write Unit

This block holds a small bank of control/status registers and carries out the six CSR access forms of a processor pipeline. Each access supplies a 12-bit register address, a 3-bit operation code, the source register index (or a 5-bit immediate in that same field), the destination index and the source register value. The unit returns the register's previous contents for the destination register, updates the register, and flags addresses that hold no register.

The three operations are:

- **Swap:** replaces the register contents.
- **Set:** ORs a mask into the register.
- **Clear:** removes the mask bits from the register.

Each operation takes its operand either from the source value or from the zero-extended 5-bit immediate. Every register has a writability mask, and bits outside that mask never change. A swap aimed at destination x0 performs no read. A set or clear whose source field is zero performs no write.

One access is accepted on every clock edge where `valid` is high. Its results appear on the outputs one cycle later, and its register update takes effect at that same edge.

Top module: `csr_rmw_unit`

## Requirements
- R1: After reset, every register holds zero and `rdData`, `rdWe`, `readStrobe` and `illegal` are all zero.
- R2: Results of an access sampled at edge N are visible on the outputs after edge N and stay for one cycle. A cycle without `valid` leaves all four outputs at zero on the following cycle.
- R3: Operation code 3'b001 (swap) writes the source value into the addressed register and returns the previous value on `rdData`.
- R4: Operation code 3'b010 ORs the source value into the register. Operation code 3'b011 ANDs the register with the inverted source value. Both return the previous value.
- R5: Operation codes 3'b101, 3'b110 and 3'b111 behave as 001, 010 and 011, except that the operand is `srcIdx` zero-extended to 32 bits.
- R6: In every form, only bits set in the register's writability mask can change. With the default parameters, the registers and masks are: 0x300 (mask 0xFFFFFFFF), 0x305 (0x0000FFFF), 0x340 (0xFFFFFF00) and 0x341 (0x8000001F).
- R7: A swap (001 or 101) with `dstIdx` zero performs no read: `readStrobe`, `rdWe` and `rdData` stay zero. The write still happens.
- R8: A set or clear (010, 011, 110, 111) with `srcIdx` zero leaves the register unchanged but still reads it.
- R9: A legal operation code at an address that holds no register raises `illegal` for one cycle. It writes nothing, and `rdWe` and `readStrobe` stay zero.
- R10: `readStrobe` marks every performed read. `rdWe` equals a performed read with a nonzero `dstIdx`. `rdData` carries the old value on a read and zero otherwise.
- R11: Operation codes 3'b000 and 3'b100 have no effect: no read, no write, and no `illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Access strobe |
| csrAddr | input | 12 | Register address |
| funct3 | input | 3 | Operation code |
| srcIdx | input | 5 | Source register index, or immediate |
| dstIdx | input | 5 | Destination register index |
| srcVal | input | 32 | Source register value |
| rdData | output | 32 | Previous register value |
| rdWe | output | 1 | Destination register write enable |
| readStrobe | output | 1 | A register read was performed |
| illegal | output | 1 | Address holds no register |

## Verification
A register corrupted by a wrong write, or a write that leaks through a masked bit, does not appear at the moment it happens. It appears on `rdData` at the next reading access to the same address. For that reason, the sweep follows every access with further accesses to the same register, which catches such errors within a few cycles. A wrong suppression decision shows at once on `readStrobe` and `rdWe`, one cycle after the access.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SWAP = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } csrOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   readEn;
    logic   writeEn;
    logic   useImm;
    csrOp_e op;
  } csrStrobe_t;

endpackage

// File: rtl/csr_rmw_ctrl.sv
module csr_rmw_ctrl
  import csr_rmw_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             valid,
  input  logic [2:0]       funct3,
  input  logic [IDX_W-1:0] srcIdx,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic             addrHit,
  output csrStrobe_t       strobe,
  output logic             rdWe,
  output logic             readStrobe,
  output logic             illegal
);

  csrOp_e opCode;
  logic   opLegal;
  logic   dstZero;

  always_comb begin
    opCode         = csrOp_e'(funct3[1:0]);
    opLegal        = valid && (opCode != OP_NONE);
    dstZero        = (dstIdx == '0);
    strobe.op      = opLegal ? opCode : OP_NONE;
    strobe.useImm  = funct3[2];
    // R7: swap into x0 suppresses the read
    strobe.readEn  = opLegal && addrHit && !((opCode == OP_SWAP) && dstZero);
    // R8: set/clear with zero source field suppresses the write
    strobe.writeEn = opLegal && addrHit && ((opCode == OP_SWAP) || (srcIdx != '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdWe       <= 1'b0;
      readStrobe <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      rdWe       <= strobe.readEn && !dstZero;
      readStrobe <= strobe.readEn;
      illegal    <= opLegal && !addrHit;
    end
  end

endmodule

// File: rtl/csr_rmw_dpath.sv
module csr_rmw_dpath
  import csr_rmw_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_CSR = 4,
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = 5,
  parameter logic [NUM_CSR-1:0][ADDR_W-1:0] CSR_ADDRS = '0,
  parameter logic [NUM_CSR-1:0][XLEN-1:0]   CSR_MASKS = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [IDX_W-1:0]  srcIdx,
  input  logic [XLEN-1:0]   srcVal,
  input  csrStrobe_t        strobe,
  output logic              addrHit,
  output logic [XLEN-1:0]   rdData
);

  logic [NUM_CSR-1:0] hitVec;
  logic [XLEN-1:0]    curVal [NUM_CSR];
  logic [XLEN-1:0]    oldVal;
  logic [XLEN-1:0]    operand;
  logic [XLEN-1:0]    newVal;

  for (genvar g = 0; g < NUM_CSR; g++) begin : g_csr
    logic [XLEN-1:0] q;
    assign hitVec[g] = (csrAddr == CSR_ADDRS[g]);
    assign curVal[g] = q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        q <= '0;
      else if (strobe.writeEn && hitVec[g])
        q <= (q & ~CSR_MASKS[g]) | (newVal & CSR_MASKS[g]);
    end
  end

  always_comb begin
    addrHit = |hitVec;
    oldVal  = '0;
    for (int i = 0; i < NUM_CSR; i++)
      if (hitVec[i]) oldVal = oldVal | curVal[i];
    operand = strobe.useImm ? XLEN'(srcIdx) : srcVal;
    unique case (strobe.op)
      OP_SWAP: newVal = operand;
      OP_SET:  newVal = oldVal | operand;
      OP_CLR:  newVal = oldVal & ~operand;
      default: newVal = oldVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else
      rdData <= strobe.readEn ? oldVal : '0;
  end

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_CSR = 4,
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = 5,
  parameter logic [NUM_CSR-1:0][ADDR_W-1:0] CSR_ADDRS =
    {12'h341, 12'h340, 12'h305, 12'h300},
  parameter logic [NUM_CSR-1:0][XLEN-1:0] CSR_MASKS =
    {32'h8000_001F, 32'hFFFF_FF00, 32'h0000_FFFF, 32'hFFFF_FFFF}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [2:0]        funct3,
  input  logic [IDX_W-1:0]  srcIdx,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [XLEN-1:0]   srcVal,
  output logic [XLEN-1:0]   rdData,
  output logic              rdWe,
  output logic              readStrobe,
  output logic              illegal
);

  csrStrobe_t strobe;
  logic       addrHit;

  csr_rmw_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .valid(valid), .funct3(funct3),
    .srcIdx(srcIdx), .dstIdx(dstIdx), .addrHit(addrHit),
    .strobe(strobe), .rdWe(rdWe), .readStrobe(readStrobe), .illegal(illegal)
  );

  csr_rmw_dpath #(
    .XLEN(XLEN), .NUM_CSR(NUM_CSR), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .CSR_ADDRS(CSR_ADDRS), .CSR_MASKS(CSR_MASKS)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .srcIdx(srcIdx),
    .srcVal(srcVal), .strobe(strobe), .addrHit(addrHit), .rdData(rdData)
  );

endmodule

// File: rtl/csr_rmw_checker.sv
module csr_rmw_checker #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             valid,
  input logic [2:0]       funct3,
  input logic [IDX_W-1:0] dstIdx,
  input logic [XLEN-1:0]  rdData,
  input logic             rdWe,
  input logic             readStrobe,
  input logic             illegal
);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !valid |=> (!readStrobe && !rdWe && !illegal));

  p_swap_x0_noread_r7: assert property (@(posedge clk) disable iff (!rstN)
    (valid && funct3[1:0] == 2'b01 && dstIdx == '0) |=> (!readStrobe && !rdWe));

  p_illegal_exclusive_r9: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!readStrobe && !rdWe));

  p_we_needs_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdWe |-> readStrobe);

  p_data_zero_noread_r10: assert property (@(posedge clk) disable iff (!rstN)
    !readStrobe |-> (rdData == '0));

  p_bad_funct3_r11: assert property (@(posedge clk) disable iff (!rstN)
    (valid && funct3[1:0] == 2'b00) |=> (!readStrobe && !illegal));

endmodule

bind csr_rmw_unit csr_rmw_checker #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .valid(valid), .funct3(funct3), .dstIdx(dstIdx),
  .rdData(rdData), .rdWe(rdWe), .readStrobe(readStrobe), .illegal(illegal)
);

// File: tb/tb_csr_rmw_unit.sv
`timescale 1ns/1ps
module tb_csr_rmw_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [2:0]  funct3 = '0;
  logic [4:0]  srcIdx = '0;
  logic [4:0]  dstIdx = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] rdData;
  logic        rdWe, readStrobe, illegal;

  int    nTests = 0;
  int    nFail = 0;
  bit    done = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [11:0] addrs [4] = '{12'h300, 12'h305, 12'h340, 12'h341};
  logic [31:0] masks [4] = '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_FF00, 32'h8000_001F};
  logic [31:0] model [4] = '{32'h0, 32'h0, 32'h0, 32'h0};

  always #2.5 clk = ~clk;

  csr_rmw_unit dut (
    .clk(clk), .rstN(rstN), .valid(valid), .csrAddr(csrAddr), .funct3(funct3),
    .srcIdx(srcIdx), .dstIdx(dstIdx), .srcVal(srcVal), .rdData(rdData),
    .rdWe(rdWe), .readStrobe(readStrobe), .illegal(illegal)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic checkOutputs(input string tag, input logic [31:0] eData,
                              input bit eWe, input bit eRd, input bit eIll);
    check(rdData == eData, {tag, "/R6 rdData"}, rdData, eData);
    check(rdWe == eWe, {tag, "/R10 rdWe"}, 32'(rdWe), 32'(eWe));
    check(readStrobe == eRd, {tag, "/R10 readStrobe"}, 32'(readStrobe), 32'(eRd));
    check(illegal == eIll, {tag, " illegal"}, 32'(illegal), 32'(eIll));
  endtask

  task automatic doOp(input logic [11:0] a, input logic [2:0] f, input logic [4:0] s,
                      input logic [4:0] d, input logic [31:0] v);
    int          hit = -1;
    bit          legalOp, eRd, eWr, eIll;
    logic [31:0] operand, newV, old, eData;
    string       tag;
    for (int i = 0; i < 4; i++) if (addrs[i] == a) hit = i;
    legalOp = (f[1:0] != 2'b00);
    eIll = legalOp && (hit < 0);
    eRd = 0; eWr = 0; old = '0;
    if (legalOp && hit >= 0) begin
      old = model[hit];
      eRd = !(f[1:0] == 2'b01 && d == 5'd0);
      eWr = (f[1:0] == 2'b01) || (s != 5'd0);
      operand = f[2] ? {27'd0, s} : v;
      case (f[1:0])
        2'b01:   newV = operand;
        2'b10:   newV = old | operand;
        default: newV = old & ~operand;
      endcase
      if (eWr) model[hit] = (old & ~masks[hit]) | (newV & masks[hit]);
    end
    eData = eRd ? old : 32'h0;
    if (!legalOp) tag = "R11";
    else if (hit < 0) tag = "R9";
    else if (f[1:0] == 2'b01 && d == 0) tag = "R7";
    else if (f[1:0] != 2'b01 && s == 0) tag = "R8";
    else if (f[2]) tag = "R5";
    else if (f[1:0] == 2'b01) tag = "R3";
    else tag = "R4";
    @(negedge clk);
    valid = 1'b1; csrAddr = a; funct3 = f; srcIdx = s; dstIdx = d; srcVal = v;
    @(negedge clk);
    valid = 1'b0;
    checkOutputs({tag, "/R2"}, eData, eRd && (d != 0), eRd, eIll);
  endtask

  initial begin
    logic [4:0] srcList [6] = '{5'd0, 5'd1, 5'd31, 5'd13, 5'd0, 5'd7};
    logic [4:0] dstList [6] = '{5'd1, 5'd0, 5'd3, 5'd0, 5'd9, 5'd31};
    logic [11:0] badAddrs [2] = '{12'h301, 12'h7FF};
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    checkOutputs("R1", 32'h0, 0, 0, 0);
    rstN = 1'b1;
    // R1: all registers read back zero
    for (int i = 0; i < 4; i++) doOp(addrs[i], 3'b010, 5'd0, 5'd1, 32'h0);
    // Fill with all ones, then sweep every form over every register
    for (int i = 0; i < 4; i++) doOp(addrs[i], 3'b001, 5'd2, 5'd1, 32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) begin
      for (int f = 0; f < 8; f++) begin
        for (int k = 0; k < 6; k++) begin
          logic [11:0] a;
          a = (i < 4) ? addrs[i] : badAddrs[i-4];
          doOp(a, 3'(f), srcList[k], dstList[k], nextRand());
          // Follow with a plain read of the same address to expose state
          doOp(a, 3'b010, 5'd0, 5'd4, 32'h0);
        end
      end
    end
    // R2: idle cycle gives quiet outputs
    @(negedge clk);
    @(negedge clk);
    checkOutputs("R2", 32'h0, 0, 0, 0);
    for (int i = 0; i < 4; i++) doOp(addrs[i], 3'b110, 5'd0, 5'd8, 32'h0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog R2 actual=%h expected=%h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule